// File: doc/BRIEF.md
# Next-PC Sequencer With Delay Slot

This block holds the program counter of a processor that runs either 32-bit instructions or 16-bit compressed instructions. It also holds a one-bit mode register that says which of the two encodings is executing. The instruction size comes from that mode bit. Each time a slot advances, the counter steps by 4 in 32-bit mode and by 2 in compressed mode. A taken branch does not redirect at once. It records its target, one more sequential instruction runs in the delay slot, and then the target is loaded.

A jump target carries the new mode in its bit 0. On load, that bit goes into the mode register and the PC bit 0 reads as zero. An exception redirect takes effect at once, whether or not the slot advances. It overrides a recorded branch and cancels it.

Two values are offered to the rest of the pipeline. The first is a link value for jump-and-link: the address after the delay slot, with bit 0 replaced by the mode bit. The second is a restart value for exception state: the current PC with bit 0 replaced by the mode bit.

Top module: `nextpc_seq`

## Requirements
- R1: After reset, `pc` equals the reset vector parameter (default 0xBFC00000), `isa_mode` is 0, and no branch is recorded.
- R2: With `slot_adv` high and no redirect due, `pc` increases by 4 when `isa_mode` is 0 and by 2 when `isa_mode` is 1, on the next clock edge.
- R3: With `slot_adv` and `exc_req` both low, `pc` and `isa_mode` keep their values.
- R4: A `br_taken` accepted with `slot_adv` makes the next slot sequential (the delay slot). The advance after that loads the recorded target.
- R5: When a target or exception vector is loaded, its bit 0 goes into `isa_mode` and `pc` bit 0 becomes 0. `pc` bit 0 is always 0.
- R6: A `br_taken` that arrives while a branch is already recorded (that is, from the delay slot) is ignored.
- R7: `exc_req` loads `exc_vector` on the next edge, even when `slot_adv` is low. It takes priority over the sequential step and the recorded target, and it cancels the recorded branch.
- R8: `exc_restart` equals `{pc[31:1], isa_mode}`.
- R9: `link_addr` equals `pc` plus twice the current instruction size, with bit 0 replaced by `isa_mode`.
- R10: `br_taken` while `slot_adv` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_adv | input | 1 | The current instruction slot completes this cycle |
| br_taken | input | 1 | The current instruction is a taken branch or jump |
| br_target | input | 32 | Branch target; bit 0 selects the new mode |
| exc_req | input | 1 | Exception redirect |
| exc_vector | input | 32 | Exception handler address; bit 0 selects the new mode |
| pc | output | 32 | Address of the current instruction |
| isa_mode | output | 1 | 0: 32-bit encoding, 1: 16-bit compressed encoding |
| link_addr | output | 32 | Return value for jump-and-link |
| exc_restart | output | 32 | Restart value for exception state |

## Verification
Straight runs of advances in each mode show that the step size follows the mode bit. Hold cycles, including a branch strobe given without an advance, separate a stalled slot from an advancing one. Branch sequences check several things: whether the delay slot really executes, whether an odd target switches the mode, and whether a second branch placed in the delay slot is dropped. Exceptions are raised while a branch is recorded and also without an advance. This separates priority and cancellation from plain redirection.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic {
    ISA_W32 = 1'b0,
    ISA_C16 = 1'b1
  } isa_e;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_SEQ  = 2'd1,
    SEL_TGT  = 2'd2,
    SEL_EXC  = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/nps_select.sv
module nps_select
  import nps_pkg::*;
(
  input  logic    slot_adv,
  input  logic    br_taken,
  input  logic    exc_req,
  input  logic    pending,
  output pc_sel_e sel,
  output logic    arm
);
  always_comb begin
    if (exc_req)       sel = SEL_EXC;
    else if (!slot_adv) sel = SEL_HOLD;
    else if (pending)  sel = SEL_TGT;
    else               sel = SEL_SEQ;
  end

  // only a sequential slot (not a delay slot) may record a branch
  assign arm = (sel == SEL_SEQ) && br_taken;
endmodule

// File: rtl/nps_pending.sv
module nps_pending #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              consume,
  input  logic [ADDR_W-1:0] target_in,
  output logic              pending,
  output logic [ADDR_W-1:0] target_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      target_q <= '0;
    end else if (arm) begin
      pending  <= 1'b1;
      target_q <= target_in;
    end else if (consume) begin
      pending  <= 1'b0;
    end
  end
endmodule

// File: rtl/nps_pc_reg.sv
module nps_pc_reg
  import nps_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_sel_e           sel,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] vector,
  output logic [ADDR_W-1:0] pc_q,
  output isa_e              mode_q,
  output logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] restart
);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_C = ADDR_W'(2);

  function automatic logic [ADDR_W-1:0] step_of(input isa_e m);
    return (m == ISA_C16) ? STEP_C : STEP_W;
  endfunction

  function automatic logic [ADDR_W-1:0] aligned(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] tag_mode(input logic [ADDR_W-1:0] a, input isa_e m);
    return {a[ADDR_W-1:1], logic'(m)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= aligned(RESET_VEC);
      mode_q <= ISA_W32;
    end else begin
      unique case (sel)
        SEL_EXC: begin
          pc_q   <= aligned(vector);
          mode_q <= isa_e'(vector[0]);
        end
        SEL_TGT: begin
          pc_q   <= aligned(target);
          mode_q <= isa_e'(target[0]);
        end
        SEL_SEQ: pc_q <= pc_q + step_of(mode_q);
        default: ;
      endcase
    end
  end

  // return past the delay slot, which runs in the same mode
  assign link    = tag_mode(pc_q + (step_of(mode_q) << 1), mode_q);
  assign restart = tag_mode(pc_q, mode_q);
endmodule

// File: rtl/nextpc_seq.sv
module nextpc_seq
  import nps_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_adv,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              exc_req,
  input  logic [ADDR_W-1:0] exc_vector,
  output logic [ADDR_W-1:0] pc,
  output logic              isa_mode,
  output logic [ADDR_W-1:0] link_addr,
  output logic [ADDR_W-1:0] exc_restart
);
  pc_sel_e           pc_sel;
  logic              branch_arm;
  logic              branch_pending;
  logic              branch_consume;
  logic [ADDR_W-1:0] branch_target_q;
  isa_e              mode_q;

  nps_select u_sel (
    .slot_adv (slot_adv),
    .br_taken (br_taken),
    .exc_req  (exc_req),
    .pending  (branch_pending),
    .sel      (pc_sel),
    .arm      (branch_arm)
  );

  assign branch_consume = (pc_sel == SEL_TGT) || (pc_sel == SEL_EXC);

  nps_pending #(.ADDR_W(ADDR_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (branch_arm),
    .consume   (branch_consume),
    .target_in (br_target),
    .pending   (branch_pending),
    .target_q  (branch_target_q)
  );

  nps_pc_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (pc_sel),
    .target  (branch_target_q),
    .vector  (exc_vector),
    .pc_q    (pc),
    .mode_q  (mode_q),
    .link    (link_addr),
    .restart (exc_restart)
  );

  assign isa_mode = logic'(mode_q);
endmodule

// File: rtl/nextpc_seq_chk.sv
module nextpc_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              br,
  input logic              exc_req,
  input logic [ADDR_W-1:0] exc_vector,
  input logic [ADDR_W-1:0] pc,
  input logic              mode,
  input logic              pending
);
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !exc_req) |=> ($stable(pc) && $stable(mode)));  // R3
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !exc_req && !pending) |=>
      (pc == $past(pc) + ($past(mode) ? ADDR_W'(2) : ADDR_W'(4))));  // R2
  AST_BRANCH_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && br && !exc_req && !pending) |=> pending);  // R4
  AST_DELAY_SLOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pending) |=> !pending);  // R6
  AST_EXC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (pc[ADDR_W-1:1] == $past(exc_vector[ADDR_W-1:1])) &&
                (mode == $past(exc_vector[0])) && !pending);  // R7
  AST_PC_HALFWORD: assert property (@(posedge clk) disable iff (!rst_n)
    pc[0] == 1'b0);  // R5
endmodule

bind nextpc_seq nextpc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adv        (slot_adv),
  .br         (br_taken),
  .exc_req    (exc_req),
  .exc_vector (exc_vector),
  .pc         (pc),
  .mode       (isa_mode),
  .pending    (branch_pending)
);

// File: tb/nextpc_seq_test.sv
module nextpc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_adv = 1'b0;
  logic        br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic        exc_req = 1'b0;
  logic [31:0] exc_vector = '0;
  logic [31:0] pc, link_addr, exc_restart;
  logic        isa_mode;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nextpc_seq uut (
    .clk(clk), .rst_n(rst_n), .slot_adv(slot_adv), .br_taken(br_taken),
    .br_target(br_target), .exc_req(exc_req), .exc_vector(exc_vector),
    .pc(pc), .isa_mode(isa_mode), .link_addr(link_addr), .exc_restart(exc_restart)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic [31:0] t,
                       input logic e, input logic [31:0] v);
    @(negedge clk);
    slot_adv = a; br_taken = b; br_target = t; exc_req = e; exc_vector = v;
    @(posedge clk);
    #1;
    slot_adv = 0; br_taken = 0; exc_req = 0;
  endtask

  task automatic expect_pc(input string tag, input logic [31:0] p, input logic m);
    chk(tag, pc, p);
    chk(tag, {31'd0, isa_mode}, {31'd0, m});
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    expect_pc("R1 reset", 32'hBFC0_0000, 1'b0);
    chk("R9 link at reset", link_addr, 32'hBFC0_0008);
    chk("R8 restart at reset", exc_restart, 32'hBFC0_0000);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_seq_wide;
    drive(1, 0, 0, 0, 0); expect_pc("R2 step4 a", 32'hBFC0_0004, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R2 step4 b", 32'hBFC0_0008, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R2 step4 c", 32'hBFC0_000C, 0);
  endtask

  task automatic t_hold;
    drive(0, 0, 0, 0, 0); expect_pc("R3 hold", 32'hBFC0_000C, 0);
    drive(0, 1, 32'h1234_5678, 0, 0); expect_pc("R10 stalled branch", 32'hBFC0_000C, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R10 no pending a", 32'hBFC0_0010, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R10 no pending b", 32'hBFC0_0014, 0);
  endtask

  task automatic t_branch;
    chk("R9 link wide", link_addr, 32'hBFC0_001C);
    drive(1, 1, 32'h8000_0100, 0, 0); expect_pc("R4 delay slot", 32'hBFC0_0018, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R4 target", 32'h8000_0100, 0);
  endtask

  task automatic t_mode_switch;
    drive(1, 1, 32'h0000_2001, 0, 0); expect_pc("R4 delay slot 2", 32'h8000_0104, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R5 odd target", 32'h0000_2000, 1);
    chk("R9 link compressed", link_addr, 32'h0000_2005);
    chk("R8 restart compressed", exc_restart, 32'h0000_2001);
    drive(1, 0, 0, 0, 0); expect_pc("R2 step2", 32'h0000_2002, 1);
  endtask

  task automatic t_branch_in_slot;
    drive(1, 1, 32'h0000_3000, 0, 0); expect_pc("R4 compressed slot", 32'h0000_2004, 1);
    drive(1, 1, 32'h0000_4000, 0, 0); expect_pc("R5 even target", 32'h0000_3000, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R6 slot branch dropped", 32'h0000_3004, 0);
  endtask

  task automatic t_exception;
    drive(1, 1, 32'h0000_5000, 0, 0); expect_pc("R7 pre", 32'h0000_3008, 0);
    drive(1, 0, 0, 1, 32'h8000_0180); expect_pc("R7 override", 32'h8000_0180, 0);
    drive(1, 0, 0, 0, 0); expect_pc("R7 branch cancelled", 32'h8000_0184, 0);
    drive(0, 0, 0, 1, 32'h9000_0001); expect_pc("R7 no advance", 32'h9000_0000, 1);
    drive(1, 0, 0, 0, 0); expect_pc("R7 after", 32'h9000_0002, 1);
  endtask

  initial begin
    t_reset();
    t_seq_wide();
    t_hold();
    t_branch();
    t_mode_switch();
    t_branch_in_slot();
    t_exception();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule